// File: doc/BRIEF.md
# Multi-channel conversion trigger scheduler

This block sits in front of a single shared converter core and decides which of a set of channels converts next. A channel is a group of settings, not a physical input: each one carries its own trigger source select, an input pin index, a sample-time setting and a priority number. Trigger events are caught and held per channel. Among the channels holding a request, the one with the lowest priority number is granted, and a tie goes to the lowest channel index.

For the granted channel the block drives the sample phase and presents the channel's pin index to the converter. It then waits for the converter's done strobe and emits a one-cycle completion pulse tagged with the channel index toward the result stage. Only one channel is in its sample or convert phase at any time. Grants are made only while the block enable and the converter ready flag are both high. A channel in back-to-back mode requests itself again as soon as it has neither a held request nor an active conversion. A trigger that reaches a channel that already has a request, or is already converting, is merged into that work and leaves a sticky overrun flag.

Top module: `cts_top`

## Requirements
- R1: After reset, samp_o, busy_o and cmpl_o are low and every overrun flag is clear.
- R2: The 3-bit trigger select of a channel is decoded as 0 = none, 1 = software bit, 2 = back-to-back, 3 = tmr_tick_i, 4 to 7 = ext_trig_i[sel-4]. An event on the selected source, while enabled, leaves a held request; events on unselected sources have no effect.
- R3: swtrig_wr_i[c] sets a software bit for channel c. The bit is consumed (turned into a request or merged) in the cycle it is seen while the select is 1, and is held unchanged while the select is any other value.
- R4: From the idle state, the held request with the lowest priority number is granted; among equal numbers the lowest channel index wins. The granted request is cleared.
- R5: The sample phase of a channel with sample setting s lasts exactly 4*s+1 clock cycles (one clock is half a converter period, so the span is 2*s+0.5 converter periods). samp_o is high throughout and samp_pin_o shows the pin index captured at the grant.
- R6: After the sample phase the block waits for conv_done_i. The cycle of the done strobe returns the block to idle, and the next grant is taken at the following clock edge, so samp_o rises in the cycle right after the completion pulse.
- R7: Each done strobe produces a single-cycle cmpl_o with cmpl_ch_o equal to the finished channel.
- R8: A trigger event on a channel that is holding a request or is converting adds no extra conversion and sets ovr_o[c], which stays set until reset.
- R9: A channel in back-to-back mode requests whenever it holds no request and is not converting, so it converts repeatedly without any other stimulus.
- R10: While en_i is low, requests and software bits are cleared, triggers are ignored and an ongoing sample or convert phase is abandoned without a completion pulse.
- R11: While conv_rdy_i is low, no grant is made; requests are still held and are served once it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, twice the converter clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable |
| conv_rdy_i | input | 1 | Converter ready flag |
| cfg_tsel_i | input | NUM_CH*3 | Trigger select per channel |
| cfg_pin_i | input | NUM_CH*PIN_W | Input pin index per channel |
| cfg_samp_i | input | NUM_CH*SAMP_W | Sample-time setting per channel |
| cfg_prio_i | input | NUM_CH*PRIO_W | Priority number per channel, lower wins |
| swtrig_wr_i | input | NUM_CH | Write-one software trigger strobes |
| tmr_tick_i | input | 1 | Internal timer event |
| ext_trig_i | input | 4 | External module or pin trigger events |
| conv_done_i | input | 1 | Conversion-done strobe from the converter |
| samp_o | output | 1 | Sample phase active |
| samp_pin_o | output | PIN_W | Pin index of the active channel |
| busy_o | output | 1 | Sample or convert phase active |
| act_ch_o | output | CH_W | Index of the active channel |
| cmpl_o | output | 1 | One-cycle completion pulse |
| cmpl_ch_o | output | CH_W | Channel index of the completion |
| ovr_o | output | NUM_CH | Sticky overrun flags |

## Verification
The assertions take for granted that the converter raises conv_done_i only while the block is in its convert phase, and that it is a single-cycle strobe; one property states this as an input rule. They also assume the configuration of a channel is not relied upon after its grant, since pin and sample setting are captured at that moment. The bench keeps within these rules by playing the converter itself: it raises the done strobe exactly three cycles into each convert phase, and it changes a channel's trigger select only between test steps, with timer, external and software events driven as single-cycle pulses.

// File: rtl/cts_pkg.sv
package cts_pkg;

  localparam int TSEL_W    = 3;
  localparam int EXT_LINES = 4;

  typedef enum logic [TSEL_W-1:0] {
    TS_OFF  = 3'd0,
    TS_SW   = 3'd1,
    TS_B2B  = 3'd2,
    TS_TMR  = 3'd3,
    TS_EXT0 = 3'd4,
    TS_EXT1 = 3'd5,
    TS_EXT2 = 3'd6,
    TS_EXT3 = 3'd7
  } tsel_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_CONV   = 2'd2
  } phase_e;

  // Decode of the trigger select: upper half picks an external line.
  function automatic logic trig_event(
    input logic [TSEL_W-1:0]    sel,
    input logic                 sw_bit,
    input logic                 b2b_free,
    input logic                 tick,
    input logic [EXT_LINES-1:0] ext
  );
    logic hit;
    if (sel[2]) begin
      hit = ext[sel[1:0]];
    end else begin
      case (sel[1:0])
        2'd1:    hit = sw_bit;
        2'd2:    hit = b2b_free;
        2'd3:    hit = tick;
        default: hit = 1'b0;
      endcase
    end
    return hit;
  endfunction

  // Sample span in clock cycles: 2*s+0.5 converter periods at double rate.
  function automatic int sample_span(input int setting);
    return 4 * setting + 1;
  endfunction

endpackage

// File: rtl/cts_chan_latch.sv
module cts_chan_latch
  import cts_pkg::*;
#(
  parameter int CH_W = 5,
  parameter int IDX  = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic [TSEL_W-1:0]    tsel_i,
  input  logic                 sw_wr_i,
  input  logic                 tick_i,
  input  logic [EXT_LINES-1:0] ext_i,
  input  logic                 busy_i,
  input  logic [CH_W-1:0]      act_ch_i,
  input  logic                 grant_i,
  output logic                 pend_o,
  output logic                 ovr_o
);

  logic sw_q, pend_q, ovr_q;
  logic busy_me, trig_w, merge_w;

  assign busy_me = busy_i && (act_ch_i == CH_W'(IDX));
  assign trig_w  = en_i && trig_event(tsel_i, sw_q, !pend_q && !busy_me, tick_i, ext_i);
  assign merge_w = trig_w && (pend_q || busy_me);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q   <= 1'b0;
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      sw_q   <= en_i && (sw_wr_i || (sw_q && (tsel_i != TS_SW)));
      pend_q <= en_i && !grant_i && (pend_q || (trig_w && !busy_me));
      ovr_q  <= ovr_q || merge_w;
    end
  end

  assign pend_o = pend_q;
  assign ovr_o  = ovr_q;

  // R8: overrun is sticky
  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q);

  // R8: a held request is not duplicated or dropped until granted
  a_r8_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && en_i && !grant_i) |=> pend_q);

  // R10: disable clears held state
  a_r10_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!pend_q && !sw_q));

  // R3: a software bit seen under software select becomes a request
  a_r3_sw_to_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && sw_q && tsel_i == TS_SW && !busy_me && !grant_i) |=> pend_q);

endmodule

// File: rtl/cts_arbiter.sv
module cts_arbiter #(
  parameter int NUM_CH = 20,
  parameter int PRIO_W = 4,
  parameter int CH_W   = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        pend_i,
  input  logic [NUM_CH*PRIO_W-1:0] prio_i,
  input  logic                     allow_i,
  output logic                     gnt_vld_o,
  output logic [CH_W-1:0]          gnt_idx_o
);

  logic              found;
  logic [CH_W-1:0]   best_idx;
  logic [PRIO_W-1:0] best_prio;

  // Strict less-than keeps the earlier (lower) index on a tie.
  always_comb begin
    found     = 1'b0;
    best_idx  = '0;
    best_prio = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (pend_i[i] && (!found || prio_i[i*PRIO_W +: PRIO_W] < best_prio)) begin
        found     = 1'b1;
        best_idx  = CH_W'(i);
        best_prio = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end

  assign gnt_vld_o = allow_i && found;
  assign gnt_idx_o = best_idx;

  // R4: the granted channel is holding a request
  a_r4_grant_pending: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld_o |-> pend_i[gnt_idx_o]);

  // R4: no pending channel beats the grant on priority or index
  always_ff @(posedge clk) begin
    if (rst_n && gnt_vld_o) begin
      for (int i = 0; i < NUM_CH; i++) begin
        a_r4_lowest_prio: assert (!(pend_i[i] &&
          ((prio_i[i*PRIO_W +: PRIO_W] < best_prio) ||
           (prio_i[i*PRIO_W +: PRIO_W] == best_prio && CH_W'(i) < gnt_idx_o))));
      end
    end
  end

endmodule

// File: rtl/cts_phase.sv
module cts_phase
  import cts_pkg::*;
#(
  parameter int PIN_W  = 5,
  parameter int SAMP_W = 4,
  parameter int CH_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              rdy_i,
  input  logic              gnt_vld_i,
  input  logic [CH_W-1:0]   gnt_idx_i,
  input  logic [SAMP_W-1:0] gnt_samp_i,
  input  logic [PIN_W-1:0]  gnt_pin_i,
  input  logic              done_i,
  output logic              idle_o,
  output logic              samp_o,
  output logic              busy_o,
  output logic [CH_W-1:0]   act_ch_o,
  output logic [PIN_W-1:0]  pin_o,
  output logic              cmpl_o,
  output logic [CH_W-1:0]   cmpl_ch_o
);

  localparam int CNT_W = SAMP_W + 2;

  phase_e            state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CH_W-1:0]   act_q, cmpl_ch_q;
  logic [PIN_W-1:0]  pin_q;
  logic              cmpl_q;
  logic [CNT_W-1:0]  load_w;

  assign load_w = CNT_W'(sample_span(int'(gnt_samp_i)) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= PH_IDLE;
      cnt_q     <= '0;
      act_q     <= '0;
      pin_q     <= '0;
      cmpl_q    <= 1'b0;
      cmpl_ch_q <= '0;
    end else begin
      cmpl_q <= 1'b0;
      if (!en_i) begin
        state_q <= PH_IDLE;
      end else begin
        case (state_q)
          PH_IDLE: begin
            if (gnt_vld_i) begin
              state_q <= PH_SAMPLE;
              act_q   <= gnt_idx_i;
              pin_q   <= gnt_pin_i;
              cnt_q   <= load_w;
            end
          end
          PH_SAMPLE: begin
            if (cnt_q == '0) state_q <= PH_CONV;
            else             cnt_q   <= cnt_q - 1'b1;
          end
          PH_CONV: begin
            if (done_i) begin
              state_q   <= PH_IDLE;
              cmpl_q    <= 1'b1;
              cmpl_ch_q <= act_q;
            end
          end
          default: state_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign idle_o    = (state_q == PH_IDLE);
  assign samp_o    = (state_q == PH_SAMPLE);
  assign busy_o    = (state_q != PH_IDLE);
  assign act_ch_o  = act_q;
  assign pin_o     = pin_q;
  assign cmpl_o    = cmpl_q;
  assign cmpl_ch_o = cmpl_ch_q;

  // R6: input rule, the converter reports done only in the convert phase
  a_r6_done_only_conv: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && en_i) |-> (state_q == PH_CONV));

  // R6: done returns to idle with a completion pulse
  a_r6_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_CONV && done_i && en_i) |=> (state_q == PH_IDLE && cmpl_q));

  // R5: an expired sample count moves to the convert phase
  a_r5_sample_to_conv: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_SAMPLE && cnt_q == '0 && en_i) |=> (state_q == PH_CONV));

  // R7: completion is a single-cycle pulse
  a_r7_cmpl_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_q |=> !cmpl_q);

  // R11: no grant leaves idle while the converter is not ready
  a_r11_hold_unready: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_IDLE && !rdy_i) |=> (state_q == PH_IDLE));

  // R10: disable abandons any phase
  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (state_q == PH_IDLE && !cmpl_q));

endmodule

// File: rtl/cts_top.sv
module cts_top
  import cts_pkg::*;
#(
  parameter int NUM_CH   = 20,
  parameter int NUM_PINS = 26,
  parameter int SAMP_W   = 4,
  parameter int PRIO_W   = 4,
  localparam int PIN_W   = $clog2(NUM_PINS),
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en_i,
  input  logic                     conv_rdy_i,
  input  logic [NUM_CH*3-1:0]      cfg_tsel_i,
  input  logic [NUM_CH*PIN_W-1:0]  cfg_pin_i,
  input  logic [NUM_CH*SAMP_W-1:0] cfg_samp_i,
  input  logic [NUM_CH*PRIO_W-1:0] cfg_prio_i,
  input  logic [NUM_CH-1:0]        swtrig_wr_i,
  input  logic                     tmr_tick_i,
  input  logic [3:0]               ext_trig_i,
  input  logic                     conv_done_i,
  output logic                     samp_o,
  output logic [PIN_W-1:0]         samp_pin_o,
  output logic                     busy_o,
  output logic [CH_W-1:0]          act_ch_o,
  output logic                     cmpl_o,
  output logic [CH_W-1:0]          cmpl_ch_o,
  output logic [NUM_CH-1:0]        ovr_o
);

  logic [NUM_CH-1:0] pend_w;
  logic              idle_w, busy_w, gnt_vld_w;
  logic [CH_W-1:0]   gnt_idx_w, act_w;
  logic [SAMP_W-1:0] gnt_samp_w;
  logic [PIN_W-1:0]  gnt_pin_w;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    cts_chan_latch #(.CH_W(CH_W), .IDX(c)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (en_i),
      .tsel_i   (cfg_tsel_i[c*TSEL_W +: TSEL_W]),
      .sw_wr_i  (swtrig_wr_i[c]),
      .tick_i   (tmr_tick_i),
      .ext_i    (ext_trig_i),
      .busy_i   (busy_w),
      .act_ch_i (act_w),
      .grant_i  (gnt_vld_w && (gnt_idx_w == CH_W'(c))),
      .pend_o   (pend_w[c]),
      .ovr_o    (ovr_o[c])
    );
  end

  cts_arbiter #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .CH_W(CH_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_i    (pend_w),
    .prio_i    (cfg_prio_i),
    .allow_i   (en_i && conv_rdy_i && idle_w),
    .gnt_vld_o (gnt_vld_w),
    .gnt_idx_o (gnt_idx_w)
  );

  // Configuration of the channel about to be granted.
  always_comb begin
    gnt_samp_w = '0;
    gnt_pin_w  = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (gnt_idx_w == CH_W'(i)) begin
        gnt_samp_w = cfg_samp_i[i*SAMP_W +: SAMP_W];
        gnt_pin_w  = cfg_pin_i[i*PIN_W +: PIN_W];
      end
    end
  end

  cts_phase #(.PIN_W(PIN_W), .SAMP_W(SAMP_W), .CH_W(CH_W)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .rdy_i      (conv_rdy_i),
    .gnt_vld_i  (gnt_vld_w),
    .gnt_idx_i  (gnt_idx_w),
    .gnt_samp_i (gnt_samp_w),
    .gnt_pin_i  (gnt_pin_w),
    .done_i     (conv_done_i),
    .idle_o     (idle_w),
    .samp_o     (samp_o),
    .busy_o     (busy_w),
    .act_ch_o   (act_w),
    .pin_o      (samp_pin_o),
    .cmpl_o     (cmpl_o),
    .cmpl_ch_o  (cmpl_ch_o)
  );

  assign busy_o   = busy_w;
  assign act_ch_o = act_w;

  // R1: nothing is active in the first cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> (!busy_o && !cmpl_o && ovr_o == '0));

  // R4: a grant is only made with the converter idle and enabled
  a_r4_single_active: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && en_i) |-> !gnt_vld_w);

endmodule

// File: tb/cts_top_tb.sv
`timescale 1ns/1ps
module cts_top_tb;

  localparam int NCH = 20;
  localparam int PW  = 5;
  localparam int SW  = 4;
  localparam int QW  = 4;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic en, rdy, tmr, done;
  logic [3:0] ext;
  logic [NCH-1:0] sw_wr;
  int sel_a[NCH], pin_a[NCH], samc_a[NCH], prio_a[NCH];
  logic [NCH*3-1:0]  tsel_v;
  logic [NCH*PW-1:0] pin_v;
  logic [NCH*SW-1:0] samp_v;
  logic [NCH*QW-1:0] prio_v;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      tsel_v[i*3 +: 3]  = 3'(sel_a[i]);
      pin_v[i*PW +: PW] = PW'(pin_a[i]);
      samp_v[i*SW +: SW] = SW'(samc_a[i]);
      prio_v[i*QW +: QW] = QW'(prio_a[i]);
    end
  end

  logic samp_o, busy_o, cmpl_o;
  logic [PW-1:0] samp_pin_o;
  logic [4:0] act_ch_o, cmpl_ch_o;
  logic [NCH-1:0] ovr_o;

  cts_top u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .conv_rdy_i(rdy),
    .cfg_tsel_i(tsel_v), .cfg_pin_i(pin_v), .cfg_samp_i(samp_v), .cfg_prio_i(prio_v),
    .swtrig_wr_i(sw_wr), .tmr_tick_i(tmr), .ext_trig_i(ext), .conv_done_i(done),
    .samp_o(samp_o), .samp_pin_o(samp_pin_o), .busy_o(busy_o), .act_ch_o(act_ch_o),
    .cmpl_o(cmpl_o), .cmpl_ch_o(cmpl_ch_o), .ovr_o(ovr_o)
  );

  // ---------------- reference model ----------------
  int m_st, m_act, m_cnt, m_ccnt, m_pin, m_cch;
  bit m_cmpl;
  bit m_pend[NCH], m_sw[NCH], m_ovr[NCH];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_act = 0; m_cnt = 0; m_ccnt = 0; m_pin = 0; m_cch = 0; m_cmpl = 0;
      for (int c = 0; c < NCH; c++) begin m_pend[c] = 0; m_sw[c] = 0; m_ovr[c] = 0; end
    end else begin
      int g;
      bit npend[NCH], nsw[NCH];
      g = -1;
      if (en && rdy && m_st == 0)
        for (int c = 0; c < NCH; c++)
          if (m_pend[c] && (g < 0 || prio_a[c] < prio_a[g])) g = c;
      for (int c = 0; c < NCH; c++) begin
        bit bz, e;
        bz = (m_st != 0) && (m_act == c);
        case (sel_a[c])
          1: e = m_sw[c];
          2: e = !m_pend[c] && !bz;
          3: e = tmr;
          4, 5, 6, 7: e = ext[sel_a[c] - 4];
          default: e = 0;
        endcase
        if (!en) e = 0;
        if (e && (m_pend[c] || bz)) m_ovr[c] = 1;
        nsw[c]   = en && (sw_wr[c] || (m_sw[c] && sel_a[c] != 1));
        npend[c] = en && (c != g) && (m_pend[c] || (e && !bz));
      end
      for (int c = 0; c < NCH; c++) begin m_pend[c] = npend[c]; m_sw[c] = nsw[c]; end
      m_cmpl = 0;
      if (!en) m_st = 0;
      else if (m_st == 0) begin
        if (g >= 0) begin m_st = 1; m_act = g; m_cnt = 4 * samc_a[g]; m_pin = pin_a[g]; end
      end else if (m_st == 1) begin
        if (m_cnt == 0) begin m_st = 2; m_ccnt = 0; end else m_cnt--;
      end else begin
        if (done) begin m_st = 0; m_cmpl = 1; m_cch = m_act; end else m_ccnt++;
      end
    end
  end

  // ---------------- checking ----------------
  int n_chk = 0, n_err = 0;
  int cyc = 0, last_cmpl = -100, rise_gap = -1;
  bit prev_samp = 0;
  int cmpl_cnt[NCH];
  int order_q[$];

  task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    logic [NCH-1:0] ev;
    for (int c = 0; c < NCH; c++) ev[c] = m_ovr[c];
    chk("R5 samp_o", samp_o == (m_st == 1), samp_o, m_st == 1);
    chk("R4 busy_o", busy_o == (m_st != 0), busy_o, m_st != 0);
    if (m_st != 0) chk("R4 act_ch_o", act_ch_o == m_act, act_ch_o, m_act);
    if (m_st == 1) chk("R5 samp_pin_o", samp_pin_o == m_pin, samp_pin_o, m_pin);
    chk("R7 cmpl_o", cmpl_o == m_cmpl, cmpl_o, m_cmpl);
    if (m_cmpl) chk("R7 cmpl_ch_o", cmpl_ch_o == m_cch, cmpl_ch_o, m_cch);
    chk("R8 ovr_o", ovr_o == ev, ovr_o, ev);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    compare_all();
    if (cmpl_o) begin
      cmpl_cnt[cmpl_ch_o]++;
      order_q.push_back(int'(cmpl_ch_o));
      last_cmpl = cyc;
    end
    if (samp_o && !prev_samp) rise_gap = cyc - last_cmpl;
    prev_samp = samp_o;
    sw_wr = '0; tmr = 0; ext = '0;
    done = (m_st == 2) && (m_ccnt == LAT - 1);
  endtask

  function automatic bit model_quiet();
    bit q;
    q = (m_st == 0);
    for (int c = 0; c < NCH; c++)
      if (m_pend[c] || (m_sw[c] && sel_a[c] == 1)) q = 0;
    return q;
  endfunction

  task automatic wait_idle();
    int n;
    n = 0;
    tick();
    while (!model_quiet() && n < 2000) begin tick(); n++; end
    tick();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    summary();
    $finish;
  end

  initial begin
    int len;
    en = 1; rdy = 1; tmr = 0; done = 0; ext = '0; sw_wr = '0;
    for (int c = 0; c < NCH; c++) begin
      sel_a[c] = 0; pin_a[c] = (c + 3) % 26; samc_a[c] = c % 4; prio_a[c] = 8; cmpl_cnt[c] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R1 reset busy", busy_o == 0, busy_o, 0);
    chk("R1 reset samp", samp_o == 0, samp_o, 0);
    chk("R1 reset cmpl", cmpl_o == 0, cmpl_o, 0);
    chk("R1 reset ovr", ovr_o == '0, ovr_o, 0);
    rst_n = 1;
    tick();

    // R5 / R2: timer-triggered channel, sample length 4*s+1
    samc_a[2] = 2; sel_a[2] = 3; tmr = 1;
    len = 0;
    tick();
    for (int i = 0; i < 200 && cmpl_cnt[2] == 0; i++) begin
      if (samp_o) begin
        len++;
        chk("R5 pin", samp_pin_o == PW'(pin_a[2]), samp_pin_o, pin_a[2]);
      end
      tick();
    end
    chk("R5 sample span", len == 9, len, 9);
    chk("R2 timer conversion", cmpl_cnt[2] == 1, cmpl_cnt[2], 1);
    sel_a[2] = 0;
    wait_idle();

    // R11 / R4 / R6: priority order with converter held not ready
    sel_a[5] = 3; sel_a[9] = 3; sel_a[12] = 3; sel_a[15] = 3;
    prio_a[5] = 6; prio_a[9] = 2; prio_a[12] = 2; prio_a[15] = 1;
    rdy = 0; tmr = 1;
    tick();
    repeat (10) tick();
    chk("R11 no grant while unready", busy_o == 0, busy_o, 0);
    order_q.delete();
    rdy = 1;
    wait_idle();
    chk("R4 order count", order_q.size() == 4, order_q.size(), 4);
    if (order_q.size() == 4) begin
      chk("R4 first", order_q[0] == 15, order_q[0], 15);
      chk("R4 second", order_q[1] == 9, order_q[1], 9);
      chk("R4 third", order_q[2] == 12, order_q[2], 12);
      chk("R4 fourth", order_q[3] == 5, order_q[3], 5);
    end
    chk("R6 next sample right after completion", rise_gap == 1, rise_gap, 1);
    sel_a[5] = 0; sel_a[9] = 0; sel_a[12] = 0; sel_a[15] = 0;

    // R8: trigger while converting is merged and flagged
    sel_a[7] = 3; tmr = 1;
    tick();
    repeat (3) tick();
    chk("R8 ch7 busy", busy_o == 1 && act_ch_o == 7, act_ch_o, 7);
    tmr = 1;
    tick();
    wait_idle();
    chk("R8 single conversion", cmpl_cnt[7] == 1, cmpl_cnt[7], 1);
    chk("R8 overrun set", ovr_o[7] == 1, ovr_o[7], 1);
    chk("R8 no overrun elsewhere", ovr_o[5] == 0, ovr_o[5], 0);
    sel_a[7] = 0;

    // R3: software bit held under another select, consumed under software select
    sel_a[11] = 4; sw_wr[11] = 1;
    tick();
    repeat (20) tick();
    chk("R3 held, no conversion", cmpl_cnt[11] == 0, cmpl_cnt[11], 0);
    sel_a[11] = 1;
    wait_idle();
    chk("R3 consumed once", cmpl_cnt[11] == 1, cmpl_cnt[11], 1);
    sw_wr[11] = 1;
    wait_idle();
    chk("R3 second write", cmpl_cnt[11] == 2, cmpl_cnt[11], 2);
    chk("R3 no overrun", ovr_o[11] == 0, ovr_o[11], 0);
    sel_a[11] = 0;

    // R9: back-to-back repeats on its own
    sel_a[1] = 2;
    repeat (80) tick();
    sel_a[1] = 0;
    wait_idle();
    chk("R9 repeated conversions", cmpl_cnt[1] >= 5, cmpl_cnt[1], 5);
    chk("R9 no overrun", ovr_o[1] == 0, ovr_o[1], 0);

    // R10: disable aborts and clears
    sel_a[3] = 3; tmr = 1;
    tick();
    tick();
    chk("R10 ch3 sampling", samp_o == 1 && act_ch_o == 3, act_ch_o, 3);
    en = 0;
    tick();
    chk("R10 aborted", busy_o == 0, busy_o, 0);
    sel_a[4] = 1; sw_wr[4] = 1;
    tick();
    repeat (3) tick();
    en = 1;
    repeat (30) tick();
    chk("R10 no completion ch3", cmpl_cnt[3] == 0, cmpl_cnt[3], 0);
    chk("R10 write ignored ch4", cmpl_cnt[4] == 0, cmpl_cnt[4], 0);
    sel_a[3] = 0; sel_a[4] = 0;

    // R2: external line decode
    sel_a[18] = 6; sel_a[19] = 7; ext = 4'b0100;
    tick();
    wait_idle();
    chk("R2 ext line 2 to ch18", cmpl_cnt[18] == 1, cmpl_cnt[18], 1);
    chk("R2 ch19 untouched", cmpl_cnt[19] == 0, cmpl_cnt[19], 0);
    sel_a[18] = 0; sel_a[19] = 0;
    repeat (5) tick();

    summary();
    $finish;
  end

endmodule